// File: doc/BRIEF.md
# SPI Hold-Condition Controller

This block sits in front of the serial engine of an SPI slave and lets a host pause a transfer without deselecting the device. It oversamples chip select, serial clock, hold and serial data in the system clock domain and decides when the link is running, paused or locked out. Bit shifting for both directions only happens while the link is running, so the shift register and bit counter keep their contents through a pause and carry on from the same bit once it ends.

A pause starts on a falling edge of the active-low hold pin while the device is selected, but only at a moment when the serial clock is low. If the clock is high, the pause waits until it falls. Leaving the pause follows the same rule. While paused, the serial clock and data input are ignored and the output driver is released. Raising chip select during a pause resets the serial interface and locks it out. Restarting then needs the hold pin released first and chip select lowered after that. Program or erase work inside the device is not affected by any of this. It is outside the block.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `hold_active`, `so_oe`, `if_reset`, `rx_valid` and `so_out` are all 0.
- R2: While selected (`cs_n_pin` low), a falling edge of `hold_n_pin` with `sclk_pin` low sets `hold_active`. It is seen three system clocks after the pin change.
- R3: If `hold_n_pin` falls while `sclk_pin` is high, `hold_active` stays 0 until `sclk_pin` goes low, and is then set.
- R4: Hold ends when `hold_n_pin` is high and `sclk_pin` is low. A rise of `hold_n_pin` with `sclk_pin` high leaves `hold_active` set until `sclk_pin` falls.
- R5: While `hold_active` is 1, `sclk_pin` and `si_pin` have no effect: no bit is shifted and the bit count is kept. After the hold ends, the byte being received completes with the remaining bits as if no pause occurred.
- R6: Data on `si_pin` is taken on each `sclk_pin` rising edge, most significant bit first, in both clock-idle-low and clock-idle-high use. After `DATA_W` bits, `rx_byte` holds the word and `rx_valid` pulses for one cycle. `so_out` takes `so_bit` on each falling edge of `sclk_pin` while running.
- R7: A rise of `cs_n_pin` while selected or held gives a single-cycle `if_reset` pulse and clears the partial bit count.
- R8: After `cs_n_pin` rises during a hold, the interface stays locked. No bits are received and no hold is shown until `hold_n_pin` and `cs_n_pin` are both high. Only a later fall of `cs_n_pin` restarts it.
- R9: `so_oe` is 1 only while selected, not held, not locked out and `out_phase` is 1.
- R10: A falling edge of `hold_n_pin` while deselected has no effect. Selecting with `hold_n_pin` already low does not start a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock pin, asynchronous |
| hold_n_pin | input | 1 | Hold pin, active low, asynchronous |
| si_pin | input | 1 | Serial data input pin |
| so_bit | input | 1 | Next output bit from the slave's transmit logic |
| out_phase | input | 1 | Slave is in a phase that drives data out |
| hold_active | output | 1 | Link is paused |
| if_reset | output | 1 | One-cycle interface reset pulse |
| so_oe | output | 1 | Output driver enable for the serial data pin |
| so_out | output | 1 | Registered serial output bit |
| rx_shift_en | output | 1 | Qualified receive shift strobe |
| tx_shift_en | output | 1 | Qualified transmit shift strobe |
| rx_byte | output | DATA_W | Last complete received word |
| rx_valid | output | 1 | Pulse when `rx_byte` is updated |

## Verification
The bench aims at the timing of hold entry and exit against the serial clock level. A design that ignores the deferral would pause on a high clock and lose or duplicate a bit. A design that never retries after deferring would stay running. The bench pauses in the middle of a byte and toggles the clock and data during the pause. It then checks that the word completes correctly, which catches a counter or shift register that keeps moving while held. It also drives chip select high during a hold and tries the restart in the wrong order. A design that skips the lockout or forgets the interface reset would then receive bytes it should drop.

// File: rtl/spi_hold_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the SPI hold-condition controller.
// Assumes the pin vector layout below is used by every module of the block.
package spi_hold_pkg;

    // Link state of the serial interface.
    typedef enum logic [1:0] {
        LNK_IDLE = 2'd0,   // deselected, waiting for chip select
        LNK_RUN  = 2'd1,   // selected, bits moving
        LNK_HOLD = 2'd2,   // selected, paused
        LNK_LOCK = 2'd3    // deselected during pause, waiting for release order
    } link_st_t;

    // Positions of the pins inside the synchronizer vector.
    localparam int PIN_CS   = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_HOLD = 2;
    localparam int PIN_SI   = 3;
    localparam int PIN_NUM  = 4;

endpackage

// File: rtl/spi_hold_sync.sv
`timescale 1ns/1ps
// Multi-bit, multi-stage synchronizer for asynchronous pins.
// Every bit gets its own flop chain. Assumes each bit is independent, so
// skew of one cycle between bits is acceptable to the consumer.
module spi_hold_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the pin value through the chain of this bit.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_hold_fsm.sv
`timescale 1ns/1ps
// Link-state machine: decides when the interface runs, pauses or locks out.
// Inputs are already synchronized. Hold entry is armed by a falling edge of
// the hold pin while running and takes effect only with the clock low. Exit
// likewise waits for a low clock. A chip-select rise while paused locks the
// link until hold and chip select are both released.
module spi_hold_fsm
    import spi_hold_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_s,      // synchronized chip select, active low
    input  logic     sclk_s,    // synchronized serial clock
    input  logic     hold_s,    // synchronized hold pin, active low
    output link_st_t state,
    output logic     hold_active,
    output logic     selected,
    output logic     if_reset
);

    link_st_t st_q, st_d;
    logic     arm_q, arm_d;
    logic     hold_prev_q;
    logic     hold_fall;
    logic     want_hold;
    logic     if_reset_q;

    assign hold_fall = hold_prev_q & ~hold_s;
    assign want_hold = (arm_q | hold_fall) & ~hold_s;

    // Next-state and arm computation.
    always_comb begin
        st_d  = st_q;
        arm_d = arm_q;
        unique case (st_q)
            LNK_IDLE: begin
                arm_d = 1'b0;
                if (!cs_s) st_d = LNK_RUN;
            end
            LNK_RUN: begin
                if (cs_s) begin
                    st_d  = LNK_IDLE;
                    arm_d = 1'b0;
                end else if (want_hold && !sclk_s) begin
                    st_d  = LNK_HOLD;
                    arm_d = 1'b0;
                end else begin
                    arm_d = want_hold;
                end
            end
            LNK_HOLD: begin
                if (cs_s)                  st_d = LNK_LOCK;
                else if (hold_s && !sclk_s) st_d = LNK_RUN;
            end
            LNK_LOCK: begin
                if (cs_s && hold_s) st_d = LNK_IDLE;
            end
            default: st_d = LNK_IDLE;
        endcase
    end

    // State, arm flag and hold-pin history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= LNK_IDLE;
            arm_q       <= 1'b0;
            hold_prev_q <= 1'b1;
        end else begin
            st_q        <= st_d;
            arm_q       <= arm_d;
            hold_prev_q <= hold_s;
        end
    end

    // Interface reset pulse on deselection of an active link.
    always_ff @(posedge clk) begin
        if (!rst_n) if_reset_q <= 1'b0;
        else        if_reset_q <= selected & cs_s;
    end

    assign state       = st_q;
    assign hold_active = (st_q == LNK_HOLD);
    assign selected    = (st_q == LNK_RUN) || (st_q == LNK_HOLD);
    assign if_reset    = if_reset_q;

    AST_ENTER_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> !$past(sclk_s) && !$past(hold_s));                   // R2
    AST_EXIT_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_active) && st_q == LNK_RUN) |-> !$past(sclk_s) && $past(hold_s)); // R4
    AST_CS_RISE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && cs_s) |=> (st_q == LNK_LOCK));                               // R8
    AST_LOCK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LNK_LOCK && !(cs_s && hold_s)) |=> (st_q == LNK_LOCK));             // R8
    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        if_reset |=> !if_reset);                                                     // R7

endmodule

// File: rtl/spi_hold_shift.sv
`timescale 1ns/1ps
// Receive shifter, bit counter and transmit output flop.
// Shifts only on strobes that the caller has already qualified, so any
// pause simply freezes the contents. Clear empties the partial word.
module spi_hold_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rx_en,
    input  logic              si_s,
    input  logic              tx_en,
    input  logic              so_bit,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              so_out
);

    localparam int               CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_next;

    assign sh_next = {sh_q[DATA_W-2:0], si_s};

    // Receive path: shift in MSB first, count bits, publish full words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else if (clr) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            rx_valid <= 1'b0;
        end else if (rx_en) begin
            sh_q <= sh_next;
            if (cnt_q == LAST) begin
                cnt_q    <= '0;
                rx_byte  <= sh_next;
                rx_valid <= 1'b1;
            end else begin
                cnt_q    <= cnt_q + 1'b1;
                rx_valid <= 1'b0;
            end
        end else begin
            rx_valid <= 1'b0;
        end
    end

    // Transmit path: present the next output bit on each qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     so_out <= 1'b0;
        else if (tx_en) so_out <= so_bit;
    end

    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !clr) |=> $stable(cnt_q) && $stable(sh_q));  // R5
    AST_VALID_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_en));                             // R6

endmodule

// File: rtl/spi_hold_ctrl.sv
`timescale 1ns/1ps
// Top of the SPI hold-condition controller.
// Synchronizes the pins, detects serial clock edges in the system clock
// domain, runs the link-state machine and gates the shift strobes and the
// output enable with it. Assumes the system clock is fast enough to see
// every serial clock level for at least two cycles.
module spi_hold_ctrl
    import spi_hold_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_pin,
    input  logic              sclk_pin,
    input  logic              hold_n_pin,
    input  logic              si_pin,
    input  logic              so_bit,
    input  logic              out_phase,
    output logic              hold_active,
    output logic              if_reset,
    output logic              so_oe,
    output logic              so_out,
    output logic              rx_shift_en,
    output logic              tx_shift_en,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam logic [PIN_NUM-1:0] PIN_RST = PIN_NUM'((1 << PIN_CS) | (1 << PIN_HOLD));

    logic [PIN_NUM-1:0] pins_raw;
    logic [PIN_NUM-1:0] pins_s;
    logic               sclk_prev_q;
    logic               sclk_rise;
    logic               sclk_fall;
    logic               selected;
    logic               running;
    link_st_t           state;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_CS]   = cs_n_pin;
        pins_raw[PIN_SCLK] = sclk_pin;
        pins_raw[PIN_HOLD] = hold_n_pin;
        pins_raw[PIN_SI]   = si_pin;
    end

    spi_hold_sync #(
        .W       (PIN_NUM),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    // Serial clock history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= pins_s[PIN_SCLK];
    end

    assign sclk_rise = pins_s[PIN_SCLK] & ~sclk_prev_q;
    assign sclk_fall = ~pins_s[PIN_SCLK] & sclk_prev_q;

    spi_hold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (pins_s[PIN_CS]),
        .sclk_s      (pins_s[PIN_SCLK]),
        .hold_s      (pins_s[PIN_HOLD]),
        .state       (state),
        .hold_active (hold_active),
        .selected    (selected),
        .if_reset    (if_reset)
    );

    assign running     = (state == LNK_RUN);
    assign rx_shift_en = running & sclk_rise;
    assign tx_shift_en = running & sclk_fall;
    assign so_oe       = running & ~pins_s[PIN_CS] & out_phase;

    spi_hold_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (~selected),
        .rx_en    (rx_shift_en),
        .si_s     (pins_s[PIN_SI]),
        .tx_en    (tx_shift_en),
        .so_bit   (so_bit),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .so_out   (so_out)
    );

    AST_NO_SHIFT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> !rx_shift_en && !tx_shift_en);          // R5
    AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> !hold_active && selected && out_phase);       // R9
    AST_QUIET_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !selected |-> !so_oe && !rx_shift_en);                  // R8

endmodule

// File: tb/sim_spi_hold_ctrl.sv
`timescale 1ns/1ps
// Bench for spi_hold_ctrl: a behavioural reference model is stepped on every
// clock and compared with the design on every falling clock edge. Directed
// checks add word values and pulse counts per scenario.
module sim_spi_hold_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n_pin = 1'b1;
    logic       sclk_pin = 1'b0;
    logic       hold_n_pin = 1'b1;
    logic       si_pin = 1'b0;
    logic       so_bit = 1'b0;
    logic       out_phase = 1'b0;
    logic       hold_active, if_reset, so_oe, so_out, rx_shift_en, tx_shift_en, rx_valid;
    logic [7:0] rx_byte;

    always #10 clk = ~clk;

    spi_hold_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sclk_pin(sclk_pin),
        .hold_n_pin(hold_n_pin), .si_pin(si_pin), .so_bit(so_bit), .out_phase(out_phase),
        .hold_active(hold_active), .if_reset(if_reset), .so_oe(so_oe), .so_out(so_out),
        .rx_shift_en(rx_shift_en), .tx_shift_en(tx_shift_en), .rx_byte(rx_byte),
        .rx_valid(rx_valid)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    int    rx_seen = 0;
    int    ifr_seen = 0;
    int    last_rx = 0;

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_st = 0;          // 0 idle, 1 run, 2 hold, 3 lock
    bit m_arm = 0;
    int c_q[$] = '{1, 1};  // two-stage delay lines, index 1 is the older value
    int k_q[$] = '{0, 0};
    int h_q[$] = '{1, 1};
    int d_q[$] = '{0, 0};
    int k_old = 0, h_old = 1;
    int m_cnt = 0, m_sh = 0, m_rxb = 0;
    bit m_rxv = 0, m_ifr = 0, m_so = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_arm = 0;
            c_q = '{1, 1}; k_q = '{0, 0}; h_q = '{1, 1}; d_q = '{0, 0};
            k_old = 0; h_old = 1;
            m_cnt = 0; m_sh = 0; m_rxb = 0; m_rxv = 0; m_ifr = 0; m_so = 0;
        end else begin
            int  cs, sk, hd, sd;
            bit  sel, up, down, hfall, want;
            cs = c_q[1]; sk = k_q[1]; hd = h_q[1]; sd = d_q[1];
            sel   = (m_st == 1) || (m_st == 2);
            up    = (sk == 1) && (k_old == 0);
            down  = (sk == 0) && (k_old == 1);
            hfall = (hd == 0) && (h_old == 1);
            if (!sel) begin
                m_cnt = 0; m_sh = 0; m_rxv = 0;
            end else if (m_st == 1 && up) begin
                m_sh = ((m_sh * 2) + sd) % 256;
                if (m_cnt == 7) begin m_rxv = 1; m_rxb = m_sh; m_cnt = 0; end
                else begin m_rxv = 0; m_cnt++; end
            end else begin
                m_rxv = 0;
            end
            if (m_st == 1 && down) m_so = so_bit;
            m_ifr = sel && (cs == 1);
            want  = (m_arm || hfall) && (hd == 0);
            case (m_st)
                0: begin m_arm = 0; if (cs == 0) m_st = 1; end
                1: begin
                    if (cs == 1) begin m_st = 0; m_arm = 0; end
                    else if (want && sk == 0) begin m_st = 2; m_arm = 0; end
                    else m_arm = want;
                end
                2: begin if (cs == 1) m_st = 3; else if (hd == 1 && sk == 0) m_st = 1; end
                default: begin if (cs == 1 && hd == 1) m_st = 0; end
            endcase
            k_old = sk; h_old = hd;
            c_q = '{int'(cs_n_pin), c_q[0]};
            k_q = '{int'(sclk_pin), k_q[0]};
            h_q = '{int'(hold_n_pin), h_q[0]};
            d_q = '{int'(si_pin), d_q[0]};
        end
    end

    // Compare design with model, and keep event counters.
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "hold_active", int'(hold_active), int'(m_st == 2));
            check(cur_req, "so_oe", int'(so_oe), int'(m_st == 1 && c_q[1] == 0 && out_phase));
            check(cur_req, "if_reset", int'(if_reset), int'(m_ifr));
            check(cur_req, "rx_valid", int'(rx_valid), int'(m_rxv));
            check(cur_req, "rx_byte", int'(rx_byte), m_rxb);
            check(cur_req, "so_out", int'(so_out), int'(m_so));
            if (if_reset) ifr_seen++;
            if (rx_valid) begin rx_seen++; last_rx = int'(rx_byte); end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic sclk_set(logic v);
        sclk_pin = v;
        idle(4);
    endtask

    task automatic send_bits(logic [7:0] v, int first, int last);
        for (int i = first; i >= last; i--) begin
            si_pin   = v[i];
            so_bit   = ~v[i];
            sclk_pin = 1'b0;
            idle(4);
            sclk_pin = 1'b1;
            idle(4);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL %s watchdog actual=timeout expected=done", cur_req);
        finish_run();
    end

    initial begin
        int rx0, ifr0;
        out_phase = 1'b1;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        cur_req = "R1";
        check("R1", "reset hold_active", int'(hold_active), 0);
        check("R1", "reset so_oe", int'(so_oe), 0);
        check("R1", "reset if_reset", int'(if_reset), 0);
        check("R1", "reset rx_valid", int'(rx_valid), 0);
        check("R1", "reset so_out", int'(so_out), 0);
        cur_req = "R9";
        idle(4);
        check("R9", "so_oe while deselected", int'(so_oe), 0);
        out_phase = 1'b0;

        // Mode 0 words, second with output phase
        cur_req = "R6";
        cs_n_pin = 1'b0; idle(6);
        send_bits(8'hA5, 7, 0); sclk_set(0); idle(6);
        check("R6", "mode0 word", last_rx, 8'hA5);
        check("R6", "mode0 count", rx_seen, 1);
        out_phase = 1'b1;
        send_bits(8'h3C, 7, 0); sclk_set(0); idle(6);
        check("R6", "second word", last_rx, 8'h3C);
        check("R9", "so_oe while running", int'(so_oe), 1);

        // Hold with clock low, activity during hold, resume
        cur_req = "R2";
        rx0 = rx_seen;
        send_bits(8'h96, 7, 5); sclk_set(0);
        hold_n_pin = 1'b0; idle(6);
        check("R2", "hold entered", int'(hold_active), 1);
        check("R9", "so_oe in hold", int'(so_oe), 0);
        cur_req = "R5";
        for (int j = 0; j < 3; j++) begin
            si_pin = j[0]; sclk_set(1); sclk_set(0);
        end
        check("R5", "no word in hold", rx_seen, rx0);
        hold_n_pin = 1'b1; idle(6);
        check("R4", "hold left", int'(hold_active), 0);
        send_bits(8'h96, 4, 0); sclk_set(0); idle(6);
        check("R5", "resumed word", last_rx, 8'h96);
        check("R5", "resumed count", rx_seen, rx0 + 1);
        out_phase = 1'b0;

        // Deferred entry and deferred exit
        cur_req = "R3";
        send_bits(8'h5A, 7, 4);
        hold_n_pin = 1'b0; idle(6);
        check("R3", "entry deferred", int'(hold_active), 0);
        sclk_pin = 1'b0; idle(4);
        check("R3", "entry after clock low", int'(hold_active), 1);
        cur_req = "R4";
        sclk_set(1);
        hold_n_pin = 1'b1; idle(6);
        check("R4", "exit deferred", int'(hold_active), 1);
        sclk_set(0); idle(2);
        check("R4", "exit after clock low", int'(hold_active), 0);
        send_bits(8'h5A, 3, 0); sclk_set(0); idle(6);
        check("R5", "word across deferred hold", last_rx, 8'h5A);

        // Deselect during hold, wrong restart order, correct restart
        cur_req = "R7";
        send_bits(8'hC3, 7, 6); sclk_set(0);
        hold_n_pin = 1'b0; idle(6);
        check("R2", "hold before deselect", int'(hold_active), 1);
        ifr0 = ifr_seen;
        cs_n_pin = 1'b1; idle(6);
        check("R7", "reset pulse count", ifr_seen, ifr0 + 1);
        check("R8", "hold dropped on deselect", int'(hold_active), 0);
        cur_req = "R8";
        rx0 = rx_seen;
        cs_n_pin = 1'b0; idle(6);
        send_bits(8'hFF, 7, 0); sclk_set(0); idle(6);
        check("R8", "locked with hold low", rx_seen, rx0);
        hold_n_pin = 1'b1; idle(6);
        send_bits(8'h0F, 7, 0); sclk_set(0); idle(6);
        check("R8", "locked after wrong order", rx_seen, rx0);
        cs_n_pin = 1'b1; idle(6);
        cs_n_pin = 1'b0; idle(6);
        send_bits(8'h81, 7, 0); sclk_set(0); idle(6);
        check("R8", "restart word", last_rx, 8'h81);
        check("R8", "restart count", rx_seen, rx0 + 1);

        // Hold pin falling while deselected
        cur_req = "R10";
        ifr0 = ifr_seen;
        cs_n_pin = 1'b1; idle(6);
        check("R7", "pulse on normal deselect", ifr_seen, ifr0 + 1);
        hold_n_pin = 1'b0; idle(6);
        cs_n_pin = 1'b0; idle(6);
        send_bits(8'h42, 7, 0); sclk_set(0); idle(6);
        check("R10", "no hold from early fall", int'(hold_active), 0);
        check("R10", "word with hold low", last_rx, 8'h42);
        hold_n_pin = 1'b1;
        cs_n_pin = 1'b1; idle(6);

        // Mode 3: clock idles high
        cur_req = "R6";
        sclk_set(1);
        cs_n_pin = 1'b0; idle(6);
        send_bits(8'hE7, 7, 0); idle(6);
        check("R6", "mode3 word", last_rx, 8'hE7);
        cs_n_pin = 1'b1; idle(6);

        finish_run();
    end

endmodule